// File: doc/BRIEF.md
# Output Compare Waveform Channel

This block is one channel of an output-compare unit. It continuously compares an externally supplied counter value with a compare value of the same width. When the counter first reaches the compare value, the block raises a one-cycle match flag. In non-PWM operation it also updates a waveform output bit as a 2-bit action field selects, and it asks the counter for a clear when this channel defines the top of a clear-on-match count.

Software can also strobe a forced compare. The force changes only the waveform bit. It raises no flag and requests no counter clear, and it acts only in non-PWM operation. The strobe is never stored, so a readback of it would always be zero.

The block also reports whether the action field takes the pin away from its ordinary port function. It enables the pin driver only when the matching direction bit is also set. The counter, prescaling, PWM waveform encodings and interrupt handling live elsewhere.

Top module: `ocu_channel`

## Requirements
- R1: `override_o` is high exactly when `com_i` is nonzero. It follows `com_i` in the same cycle.
- R2: `pin_oe_o` is high exactly when `override_o` is high and `ddr_i` is high, in the same cycle.
- R3: `match_o` is high for one cycle, in the cycle after the first cycle in which `count_i` equals `cmp_val_i`. While the two stay equal, no further pulse occurs until they have differed for at least one cycle.
- R4: On a real match with `pwm_mode_i` low, the `com_i` value sampled in the matching cycle sets `wave_o` for the next cycle: 2'b00 leaves it unchanged, 2'b01 inverts it, 2'b10 drives it to 0 and 2'b11 drives it to 1.
- R5: A high `force_wr_i` with `pwm_mode_i` low applies the same `com_i` action to `wave_o` in the next cycle, whatever the compare result.
- R6: A forced compare never raises `match_o` or `ctc_clr_o`.
- R7: `force_wr_i` has no effect on `wave_o` while `pwm_mode_i` is high.
- R8: `ctc_clr_o` is high for one cycle together with `match_o` when the real match was seen with `ctc_top_i` high and `pwm_mode_i` low. Otherwise it is low.
- R9: While `pwm_mode_i` is high, a real match still pulses `match_o`, but `wave_o` does not change.
- R10: While `rst_ni` is low, `wave_o`, `match_o` and `ctc_clr_o` are 0.
- R11: When a real match and a force occur in the same cycle, the `com_i` action is applied once. A toggle therefore inverts `wave_o` a single time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| count_i | input | CNT_W | Counter value |
| cmp_val_i | input | CNT_W | Compare value |
| pwm_mode_i | input | 1 | 1 = a PWM mode is active, 0 = normal or clear-on-match mode |
| ctc_top_i | input | 1 | Clear-on-match mode is active with this channel as top |
| com_i | input | 2 | Compare output action field |
| force_wr_i | input | 1 | Forced compare strobe (one-cycle write) |
| ddr_i | input | 1 | Data-direction bit of the pin |
| wave_o | output | 1 | Waveform output bit |
| override_o | output | 1 | Compare output owns the pin |
| pin_oe_o | output | 1 | Pin driver enable |
| match_o | output | 1 | One-cycle match flag |
| ctc_clr_o | output | 1 | Counter clear request |

## Verification
On every cycle, the assertions check the following:
- The pin ownership and driver-enable relations hold.
- The match flag never lasts two cycles.
- A clear request never appears without a match.
- A force on unequal values never flags.
- The waveform bit holds in PWM mode and under the disconnect action.

The exact action results need the bench's sweeps: which level the bit takes after toggle, clear or set; the single toggle when a force and a match coincide; and the suppression of a repeated match while the counter holds the compare value.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

  typedef enum logic [1:0] {
    COM_OFF = 2'b00,
    COM_TGL = 2'b01,
    COM_CLR = 2'b10,
    COM_SET = 2'b11
  } com_e;

  // next waveform level for a compare action
  function automatic logic com_apply(input com_e mode, input logic cur);
    case (mode)
      COM_TGL: com_apply = ~cur;
      COM_CLR: com_apply = 1'b0;
      COM_SET: com_apply = 1'b1;
      default: com_apply = cur;
    endcase
  endfunction

endpackage

// File: rtl/ocu_cmp.sv
module ocu_cmp #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  output logic             hit_o
);
  logic eq, eq_q;

  assign eq = (count_i == cmp_val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= 1'b0;
    else         eq_q <= eq;
  end

  // fire only on entry into equality
  assign hit_o = eq & ~eq_q;
endmodule

// File: rtl/ocu_wave.sv
module ocu_wave
  import ocu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit_i,
  input  logic       force_i,
  input  logic       pwm_mode_i,
  input  logic [1:0] com_i,
  output logic       wave_o
);
  logic act;
  logic wave_q;

  // one action per cycle, even when force and hit coincide
  assign act = ~pwm_mode_i & (hit_i | force_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  wave_q <= 1'b0;
    else if (act) wave_q <= com_apply(com_e'(com_i), wave_q);
  end

  assign wave_o = wave_q;
endmodule

// File: rtl/ocu_evt.sv
module ocu_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic pwm_mode_i,
  input  logic ctc_top_i,
  output logic match_o,
  output logic ctc_clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_o   <= 1'b0;
      ctc_clr_o <= 1'b0;
    end else begin
      match_o   <= hit_i;
      ctc_clr_o <= hit_i & ctc_top_i & ~pwm_mode_i;
    end
  end
endmodule

// File: rtl/ocu_pin.sv
module ocu_pin (
  input  logic [1:0] com_i,
  input  logic       ddr_i,
  output logic       override_o,
  output logic       pin_oe_o
);
  assign override_o = |com_i;
  assign pin_oe_o   = override_o & ddr_i;
endmodule

// File: rtl/ocu_channel.sv
module ocu_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic             pwm_mode_i,
  input  logic             ctc_top_i,
  input  logic [1:0]       com_i,
  input  logic             force_wr_i,
  input  logic             ddr_i,
  output logic             wave_o,
  output logic             override_o,
  output logic             pin_oe_o,
  output logic             match_o,
  output logic             ctc_clr_o
);
  logic hit;

  ocu_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .count_i   (count_i),
    .cmp_val_i (cmp_val_i),
    .hit_o     (hit)
  );

  ocu_wave u_wave (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit),
    .force_i    (force_wr_i),
    .pwm_mode_i (pwm_mode_i),
    .com_i      (com_i),
    .wave_o     (wave_o)
  );

  // force strobe intentionally not routed here
  ocu_evt u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit),
    .pwm_mode_i (pwm_mode_i),
    .ctc_top_i  (ctc_top_i),
    .match_o    (match_o),
    .ctc_clr_o  (ctc_clr_o)
  );

  ocu_pin u_pin (
    .com_i      (com_i),
    .ddr_i      (ddr_i),
    .override_o (override_o),
    .pin_oe_o   (pin_oe_o)
  );
endmodule

// File: rtl/ocu_channel_chk.sv
module ocu_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] count_i,
  input logic [CNT_W-1:0] cmp_val_i,
  input logic             pwm_mode_i,
  input logic [1:0]       com_i,
  input logic             force_wr_i,
  input logic             ddr_i,
  input logic             wave_o,
  input logic             override_o,
  input logic             pin_oe_o,
  input logic             match_o,
  input logic             ctc_clr_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R1
  override_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (com_i != 2'b00) |-> override_o);

  // R2
  pin_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o |-> (ddr_i && override_o));

  // R3
  match_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);

  // R8
  ctc_needs_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctc_clr_o |-> match_o);

  // R6
  force_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(force_wr_i) && $past(count_i != cmp_val_i)) |-> !match_o);

  // R7
  pwm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(pwm_mode_i)) |-> $stable(wave_o));

  // R4
  com_off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(com_i == 2'b00)) |-> $stable(wave_o));
endmodule

bind ocu_channel ocu_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .count_i    (count_i),
  .cmp_val_i  (cmp_val_i),
  .pwm_mode_i (pwm_mode_i),
  .com_i      (com_i),
  .force_wr_i (force_wr_i),
  .ddr_i      (ddr_i),
  .wave_o     (wave_o),
  .override_o (override_o),
  .pin_oe_o   (pin_oe_o),
  .match_o    (match_o),
  .ctc_clr_o  (ctc_clr_o)
);

// File: tb/ocu_channel_test.sv
`timescale 1ns/1ps
module ocu_channel_test;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cnt = '0, cmp = '0;
  logic         pwm = 1'b0, ctop = 1'b0, frc = 1'b0, ddr = 1'b0;
  logic [1:0]   com = 2'b00;
  logic         wave, ovr, oe, match, ctc;

  int total = 0, bad = 0;
  logic m_wave = 1'b0, m_peq = 1'b0, m_match = 1'b0, m_ctc = 1'b0;
  string wtag = "R4";
  string mtag = "R3";

  always #2 clk = ~clk;

  ocu_channel #(.CNT_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .count_i(cnt), .cmp_val_i(cmp),
    .pwm_mode_i(pwm), .ctc_top_i(ctop), .com_i(com), .force_wr_i(frc),
    .ddr_i(ddr), .wave_o(wave), .override_o(ovr), .pin_oe_o(oe),
    .match_o(match), .ctc_clr_o(ctc)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // one clock: model follows requirements, compare at the falling edge
  task automatic step();
    logic eq, ev, act;
    @(posedge clk);
    eq = (cnt == cmp);
    ev = eq && !m_peq;
    act = !pwm && (ev || frc);
    if (act) begin
      case (com)
        2'b01: m_wave = ~m_wave;
        2'b10: m_wave = 1'b0;
        2'b11: m_wave = 1'b1;
        default: ;
      endcase
    end
    m_match = ev;
    m_ctc = ev && ctop && !pwm;
    m_peq = eq;
    if (pwm) wtag = frc ? "R7" : "R9";
    else if (frc && ev) wtag = "R11";
    else if (frc) wtag = "R5";
    else wtag = "R4";
    mtag = frc ? "R6" : "R3";
    @(negedge clk);
    chk(wtag, wave, m_wave);
    chk(mtag, match, m_match);
    chk(frc ? "R6" : "R8", ctc, m_ctc);
    chk("R1", ovr, com != 2'b00);
    chk("R2", oe, (com != 2'b00) && ddr);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cnt = 4'd3; cmp = 4'd3; com = 2'b11; frc = 1'b1;
    #10;
    // R10 outputs held low in reset despite match and force inputs
    chk("R10", wave, 1'b0);
    chk("R10", match, 1'b0);
    chk("R10", ctc, 1'b0);
    @(negedge clk);
    cnt = 4'd0; frc = 1'b0; com = 2'b00;
    rst_n = 1'b1;

    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 4; c++) begin
        for (int v = 0; v < 16; v++) begin
          pwm = p[0]; com = c[1:0]; cmp = v[W-1:0];
          ddr = v[0]; ctop = v[1];
          for (int k = 0; k < 34; k++) begin
            cnt = W'((k / 2) % 16);   // each value held two cycles (R3)
            frc = (k % 7 == 3);
            step();
          end
        end
      end
    end

    // R11 directed: toggle with coincident match and force
    pwm = 1'b0; com = 2'b01; cmp = 4'd5; frc = 1'b0; cnt = 4'd4;
    step();
    cnt = 4'd5; frc = 1'b1;
    step();
    frc = 1'b0;
    step();
    // R7 directed: force in PWM mode with set action
    pwm = 1'b1; com = 2'b11; cnt = 4'd9; frc = 1'b1;
    step();
    frc = 1'b0;
    step();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule